// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Write Sequencer

This block drives a serial EEPROM over a four-wire SPI link and performs one byte write for each request it accepts. A request carries a 16-bit memory address and a data byte. It is accepted with a valid/ready handshake. The block then frames two separate chip-select windows. The first window unlocks the device with the write-enable opcode. The second window carries the write opcode, the address and the data byte.

After the second window closes, the block waits a programmable number of system clocks. This covers the device's internal programming time, which is roughly 5 ms. The block then pulses `done` and returns to accepting requests. The serial clock is derived from the system clock by a parameterised divider. The link runs in mode 0: the clock idles low, the device samples on the rising edge, and data moves on the falling edge.

Top module: `eeprom_byte_writer`

## Requirements
- R1: Out of reset, and at any time `rstN` is low, `spiCsN` is 1, `spiSck` is 0, `done` is 0 and `reqReady` is 1.
- R2: A request is accepted on a rising clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the next cycle through the cycle in which `done` is high, and is 1 again in the cycle after.
- R3: `spiCsN` falls in the cycle after acceptance. The first low window carries exactly 8 bits, equal to 0x06, and then `spiCsN` returns to 1.
- R4: Between the two windows, `spiCsN` stays high for at least two SCK periods (4 × CLK_DIV system clocks).
- R5: The second low window carries exactly 32 bits: 0x02, then address bits 15..8, then address bits 7..0, then the data byte. Address and data are captured at acceptance, and later changes on `reqAddr`/`reqData` have no effect on them.
- R6: Every byte is sent most significant bit first. `spiSck` is 0 whenever `spiCsN` is 1. `spiMosi` holds steady while `spiSck` is high, so each bit is taken on a rising SCK edge.
- R7: Each SCK high phase and each SCK low phase lasts CLK_DIV system clocks. A window of n bits therefore holds SCK high for n × CLK_DIV clocks.
- R8: `done` is high for exactly one clock, in the WAIT_CYCLES-th cycle that `spiCsN` is high after the second window closes.
- R9: `reqValid` asserted while a write is in progress is ignored. The frames of the write in flight are unchanged, and no new window opens after `done` if `reqValid` has dropped by then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Target memory address |
| reqData | input | DATA_W | Byte to be written |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the device |
| spiCsN | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle pulse when the programming wait ends |

## Verification
A corrupted sequencer state shows up on `spiCsN` within one clock. A chip select that opens at the wrong time, or an extra window, is visible to the bench as a wrong window count, and any SCK activity while deselected is caught at once. A datapath fault, such as a wrong bit count, a wrong shift direction or a stale address, changes the captured frame value or its length by the end of that window. A wait-counter fault moves the `done` pulse away from the expected cycle after the final CS rise, or widens it beyond one cycle.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_WREN  = 8'h06;
  localparam logic [OP_W-1:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WEN,
    ST_DESEL,
    ST_WRITE,
    ST_BURN
  } ebwState_t;

  typedef struct packed {
    logic loadWen;    // capture request, load enable opcode
    logic loadWr;     // load write opcode, address and data
    logic xferEn;     // serial clock generation active
    logic loadDesel;  // start deselect interval
    logic loadWait;   // start programming interval
  } ebwStrobes_t;

endpackage

// File: rtl/ebw_ctrl.sv
module ebw_ctrl
  import ebw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        xferDone,
  input  logic        cntZero,
  output ebwStrobes_t strobes,
  output logic        reqReady,
  output logic        csN,
  output logic        done
);

  ebwState_t state, nextState;
  logic      csNReg;

  always_comb begin
    nextState = state;
    strobes   = '0;
    strobes.xferEn = (state == ST_WEN) || (state == ST_WRITE);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.loadWen = 1'b1;
          nextState       = ST_WEN;
        end
      end
      ST_WEN: begin
        if (xferDone) begin
          strobes.loadDesel = 1'b1;
          nextState         = ST_DESEL;
        end
      end
      ST_DESEL: begin
        if (cntZero) begin
          strobes.loadWr = 1'b1;
          nextState      = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (xferDone) begin
          strobes.loadWait = 1'b1;
          nextState        = ST_BURN;
        end
      end
      ST_BURN: begin
        if (cntZero) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      csNReg <= 1'b1;
    end else begin
      state  <= nextState;
      csNReg <= !((nextState == ST_WEN) || (nextState == ST_WRITE));
    end
  end

  assign csN      = csNReg;
  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_BURN) && cntZero;

endmodule

// File: rtl/ebw_datapath.sv
module ebw_datapath
  import ebw_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int DESEL_CYC = 16,
  parameter int WAIT_CYC  = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebwStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              sck,
  output logic              mosi,
  output logic              xferDone,
  output logic              cntZero
);

  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int MAX_CNT = (DESEL_CYC > WAIT_CYC) ? DESEL_CYC : WAIT_CYC;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  logic [FRAME_W-1:0] shiftReg;
  logic [BIT_W-1:0]   bitsLeft;
  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic               sckReg;
  logic               tick;
  logic [CNT_W-1:0]   cnt;
  logic               anyLoad;

  assign anyLoad = strobes.loadWen || strobes.loadWr;

  // half-period tick generation
  generate
    if (CLK_DIV == 1) begin : g_noDiv
      assign tick = strobes.xferEn;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             divCnt <= '0;
        else if (!strobes.xferEn || anyLoad)   divCnt <= '0;
        else if (divCnt == DIV_W'(CLK_DIV - 1)) divCnt <= '0;
        else                                   divCnt <= divCnt + 1'b1;
      end
      assign tick = strobes.xferEn && (divCnt == DIV_W'(CLK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckReg <= 1'b0;
    else if (anyLoad || !strobes.xferEn) sckReg <= 1'b0;
    else if (tick) sckReg <= !sckReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
    end else if (strobes.loadWen) begin
      shiftReg <= {OP_WREN, {(FRAME_W - OP_W){1'b0}}};
      bitsLeft <= BIT_W'(OP_W);
      addrQ    <= reqAddr;
      dataQ    <= reqData;
    end else if (strobes.loadWr) begin
      shiftReg <= {OP_WRITE, addrQ, dataQ};
      bitsLeft <= BIT_W'(FRAME_W);
    end else if (tick && sckReg) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  // interval counter shared by deselect and programming waits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (strobes.loadDesel) cnt <= CNT_W'(DESEL_CYC - 1);
    else if (strobes.loadWait)  cnt <= CNT_W'(WAIT_CYC - 1);
    else if (cnt != '0)         cnt <= cnt - 1'b1;
  end

  assign xferDone = tick && sckReg && (bitsLeft == BIT_W'(1));
  assign cntZero  = (cnt == '0);
  assign sck      = sckReg;
  assign mosi     = shiftReg[FRAME_W-1];

endmodule

// File: rtl/eeprom_byte_writer.sv
module eeprom_byte_writer
  import ebw_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int DESEL_SCK   = 2,
  parameter int WAIT_CYCLES = 250000,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              spiSck,
  output logic              spiMosi,
  output logic              spiCsN,
  output logic              done
);

  localparam int DESEL_CYC = 2 * DESEL_SCK * CLK_DIV;

  ebwStrobes_t strobes;
  logic        xferDone;
  logic        cntZero;

  ebw_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .xferDone (xferDone),
    .cntZero  (cntZero),
    .strobes  (strobes),
    .reqReady (reqReady),
    .csN      (spiCsN),
    .done     (done)
  );

  ebw_datapath #(
    .CLK_DIV   (CLK_DIV),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DESEL_CYC (DESEL_CYC),
    .WAIT_CYC  (WAIT_CYCLES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .sck      (spiSck),
    .mosi     (spiMosi),
    .xferDone (xferDone),
    .cntZero  (cntZero)
  );

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
  parameter int CLK_DIV   = 4,
  parameter int DESEL_SCK = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic spiSck,
  input logic spiMosi,
  input logic spiCsN,
  input logic done
);

  localparam int MIN_GAP = 2 * DESEL_SCK * CLK_DIV;

  logic [15:0] highRun;
  logic        seenLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= '0;
      seenLow <= 1'b0;
    end else begin
      if (!spiCsN) begin
        highRun <= '0;
        seenLow <= 1'b1;
      end else if (highRun != 16'hFFFF) begin
        highRun <= highRun + 1'b1;
      end
    end
  end

  // R6
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  // R6
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi));

  // R2
  busy_while_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> !reqReady);

  // R3
  select_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!spiCsN && !reqReady));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

  // R4
  deselect_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(spiCsN) && seenLow) |-> (int'(highRun) >= MIN_GAP));

endmodule

bind eeprom_byte_writer ebw_checker #(
  .CLK_DIV   (CLK_DIV),
  .DESEL_SCK (DESEL_SCK)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .spiSck   (spiSck),
  .spiMosi  (spiMosi),
  .spiCsN   (spiCsN),
  .done     (done)
);

// File: tb/eeprom_byte_writer_tb_top.sv
module eeprom_byte_writer_tb_top;

  localparam int CLK_DIV     = 2;
  localparam int DESEL_SCK   = 2;
  localparam int WAIT_CYCLES = 40;
  localparam int NVEC        = 4;
  // {address, data}
  localparam logic [23:0] VECS [NVEC] = '{24'h12C35A, 24'hFFFF00, 24'h0000FF, 24'h8001A5};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        sck, mosi, csN, done;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = !clk;

  eeprom_byte_writer #(
    .CLK_DIV     (CLK_DIV),
    .DESEL_SCK   (DESEL_SCK),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .spiSck   (sck),
    .spiMosi  (mosi),
    .spiCsN   (csN),
    .done     (done)
  );

  // ---------------- bus monitor ----------------
  int          frameIdx = 0, fallCnt = 0, doneRises = 0, doneHigh = 0;
  int          gapCnt = 0, doneK = 0, modeViol = 0, bitCnt = 0, highCnt = 0;
  logic [31:0] frameBits = '0;
  logic [31:0] frames [32];
  int          frameBitsN [32];
  int          frameHigh [32];
  int          gapArr [32];
  logic        readyAtDone = 1'b0;
  logic        prevCs = 1'b1, prevSck = 1'b0, prevMosi = 1'b0, prevDone = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs <= 1'b1; prevSck <= 1'b0; prevMosi <= 1'b0; prevDone <= 1'b0;
    end else begin
      prevCs <= csN; prevSck <= sck; prevMosi <= mosi; prevDone <= done;
      if (csN && sck) modeViol <= modeViol + 1;
      if (!csN && sck && prevSck && (mosi !== prevMosi)) modeViol <= modeViol + 1;
      if (!csN) begin
        if (prevCs) begin
          if (frameIdx < 32) gapArr[frameIdx] <= gapCnt;
          fallCnt   <= fallCnt + 1;
          frameBits <= '0;
          bitCnt    <= 0;
          highCnt   <= 0;
        end else begin
          if (sck && !prevSck) begin
            frameBits <= {frameBits[30:0], mosi};
            bitCnt    <= bitCnt + 1;
          end
          if (sck) highCnt <= highCnt + 1;
        end
        gapCnt <= 0;
      end else begin
        if (!prevCs && frameIdx < 32) begin
          frames[frameIdx]     <= frameBits;
          frameBitsN[frameIdx] <= bitCnt;
          frameHigh[frameIdx]  <= highCnt;
          frameIdx             <= frameIdx + 1;
        end
        gapCnt <= gapCnt + 1;
      end
      if (done) begin
        doneHigh <= doneHigh + 1;
        if (!prevDone) begin
          doneRises   <= doneRises + 1;
          doneK       <= csN ? gapCnt + 1 : -1;
          readyAtDone <= reqReady;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string what);
    chk(csN == 1'b1, "R1", {what, " csN"}, csN, 1);
    chk(sck == 1'b0, "R1", {what, " sck"}, sck, 0);
    chk(done == 1'b0, "R1", {what, " done"}, done, 0);
    chk(reqReady == 1'b1, "R1", {what, " ready"}, reqReady, 1);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, input bit disturb);
    int base, dR, dH, fb;
    logic [31:0] expFrame;
    expFrame = {8'h02, a, d};
    @(negedge clk);
    chk(reqReady == 1'b1, "R2", "ready before request", reqReady, 1);
    base = frameIdx; dR = doneRises; dH = doneHigh;
    reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;
    chk(reqReady == 1'b0, "R2", "ready after accept", reqReady, 0);
    if (disturb) begin
      repeat (60) @(negedge clk);
      reqValid = 1'b1; reqAddr = 16'h0F0F; reqData = 8'hC3;
      repeat (20) @(negedge clk);
      reqValid = 1'b0;
    end
    for (int i = 0; i < 5000 && doneRises == dR; i++) @(negedge clk);
    chk(reqReady == 1'b1, "R2", "ready after done", reqReady, 1);
    chk(readyAtDone == 1'b0, "R2", "ready during done", readyAtDone, 0);
    chk(frameIdx - base == 2, "R3", "window count", frameIdx - base, 2);
    chk(frames[base] == 32'h06 && frameBitsN[base] == 8, "R3", "enable frame",
        frames[base], 32'h06);
    chk(frameBitsN[base+1] == 32, "R5", "write frame length", frameBitsN[base+1], 32);
    chk(frames[base+1] == expFrame, "R5", "write frame value MSB first (R6)",
        frames[base+1], expFrame);
    chk(gapArr[base+1] >= 4 * CLK_DIV, "R4", "deselect gap", gapArr[base+1], 4 * CLK_DIV);
    chk(frameHigh[base] == 8 * CLK_DIV, "R7", "enable SCK high time",
        frameHigh[base], 8 * CLK_DIV);
    chk(frameHigh[base+1] == 32 * CLK_DIV, "R7", "write SCK high time",
        frameHigh[base+1], 32 * CLK_DIV);
    chk(doneK == WAIT_CYCLES, "R8", "done position", doneK, WAIT_CYCLES);
    chk(doneHigh - dH == 1, "R8", "done width", doneHigh - dH, 1);
    if (disturb) begin
      fb = fallCnt;
      repeat (30) @(negedge clk);
      chk(fallCnt == fb, "R9", "no window after busy request", fallCnt - fb, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    chkIdle("in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkIdle("after reset");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      doWrite(VECS[v][23:8], VECS[v][7:0], 1'b0);
    end

    // R9: request while busy is ignored
    doWrite(16'h3C01, 8'h7E, 1'b1);

    // R1: reset in the middle of a transfer
    @(negedge clk);
    reqAddr = 16'h4242; reqData = 8'h24; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (15) @(negedge clk);
    chk(csN == 1'b0, "R3", "selected mid-transfer", csN, 0);
    rstN = 1'b0;
    @(negedge clk);
    chkIdle("reset mid-transfer");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // a full write after the interrupted one
    doWrite(16'h00F1, 8'h81, 1'b0);

    chk(modeViol == 0, "R6", "mode 0 violations", modeViol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule